// File: doc/BRIEF.md
# GPIO Port with Alternate-Function Muxing

This block is an 8-bit general-purpose I/O port on a simple synchronous register bus. Three registers control it: an output latch, a direction register and a function register. For each pin, the direction bit and the function bit are read together as one two-bit mode. The four modes are plain input, external interrupt input, plain output driven from the latch, and output driven by a timer.

Only pins 0, 1, 3, 5 and 6 exist. Pins 2, 4 and 7 never drive their pads and always read as zero.

Pin 0 has no function select. Its synchronized pad level feeds the timer input at all times.

Pad inputs go through a two-flop synchronizer. The data-register read path, the interrupt request lines and the timer input all take the synchronized level.

The direction and function registers are write-only. The bus returns zero when software reads them.

Top module: `gpio_altfn_port`

## Requirements
- R1: After reset, every direction bit and every function bit is 0, and the output latch holds 1 in each implemented bit. So the first time pin 3 is made an output, it drives 1 before any write to the data register.
- R2: A bus write takes effect at the rising clock edge where bus_sel=1 and bus_wr=1. Offset 0x32 sets direction (1 = output). pad_oe equals the stored direction bits, and pad_oe is always 0 on pins 2, 4 and 7.
- R3: Offset 0x30 writes the output latch. When the function bit is 0, or the pin is 3 or 0, pad_out carries the latch bit. Bits 2, 4 and 7 of pad_out are always 0.
- R4: Offset 0x33 writes the function bits for pins 1, 3, 5 and 6. When both the direction bit and the function bit are 1, the pad output comes from a timer: pin 1 takes tmr_a1_out, pin 5 takes tmr_a3_out and pin 6 takes tmr_b0_out0. Pin 3 in this mode still drives its latch bit.
- R5: irq_req bits map to pins as follows: bit 0 to pin 3, bit 1 to pin 1, bit 2 to pin 5, bit 3 to pin 6. Each bit equals the pin's synchronized pad level when that pin has direction 0 and function 1. In every other mode the bit is 0.
- R6: A change on pad_in reaches the read path, irq_req and tmr_in0 after exactly two rising clock edges.
- R7: A read (bus_sel=1, bus_wr=0) at offset 0x30 returns bus_rdata in the same cycle. For pins 0, 1, 5 and 6, in any mode, each bit shows the synchronized pad level. Pin 3 shows the latch bit when it is an output and the synchronized pad level when it is an input.
- R8: Reads of offsets 0x32 and 0x33, reads of any other offset, and bus_rdata whenever no read is in progress all return 0. Bits 2, 4 and 7 of a data read are 0.
- R9: tmr_in0 always equals the synchronized level of pin 0, whatever the register contents.
- R10: The following writes change nothing: writes to other offsets, writes to bits 2, 4 and 7, and writes to bit 0 of the function register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| tmr_a1_out | input | 1 | Timer output routed to pin 1 |
| tmr_a3_out | input | 1 | Timer output routed to pin 5 |
| tmr_b0_out0 | input | 1 | Timer output routed to pin 6 |
| tmr_in0 | output | 1 | Synchronized pin 0 level for a timer input |
| irq_req | output | 4 | Interrupt requests from pins 3, 1, 5, 6 |

## Verification
The assertions assume that bus_sel, bus_wr, bus_addr, pad_in and the timer inputs carry known values at every rising edge. They also assume that the timer outputs can be compared with pad_out in the same cycle, because the block has no register on that path. The stimulus changes every input only on the falling clock edge and always drives defined values. It draws offsets mostly from the four around the data register and adds occasional random offsets. Because of this, the mode decode, the write-only registers and the ignored-offset cases are all covered while the inputs stay inside those assumptions.

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port #(
  parameter int              AW         = 8,
  parameter int              DW         = 8,
  parameter logic [AW-1:0]   OFF_DATA   = 8'h30,
  parameter logic [AW-1:0]   OFF_DIR    = 8'h32,
  parameter logic [AW-1:0]   OFF_FUNC   = 8'h33,
  parameter logic [DW-1:0]   PIN_MASK   = 8'h6B,
  parameter logic [DW-1:0]   FUNC_MASK  = 8'h6A,
  parameter logic [DW-1:0]   PADRB_MASK = 8'h63,
  parameter int              PIN_TA1    = 1,
  parameter int              PIN_TA3    = 5,
  parameter int              PIN_TB0    = 6,
  parameter int              PIN_INT0   = 3,
  parameter int              PIN_TIN    = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] pad_out,
  output logic [DW-1:0] pad_oe,
  input  logic          tmr_a1_out,
  input  logic          tmr_a3_out,
  input  logic          tmr_b0_out0,
  output logic          tmr_in0,
  output logic [3:0]    irq_req
);
  localparam logic [DW-1:0] TMR_MASK = (DW'(1) << PIN_TA1) | (DW'(1) << PIN_TA3) | (DW'(1) << PIN_TB0);

  logic [DW-1:0] latch_q, dir_q, func_q, sync1_q, sync2_q;
  logic [DW-1:0] tmr_vec, timer_sel, irq_mode, view;

  wire wr_en = bus_sel & bus_wr;
  wire rd_en = bus_sel & ~bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= PIN_MASK;
      dir_q   <= '0;
      func_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in & PIN_MASK;
      sync2_q <= sync1_q;
      if (wr_en && bus_addr == OFF_DATA) latch_q <= bus_wdata & PIN_MASK;
      if (wr_en && bus_addr == OFF_DIR)  dir_q   <= bus_wdata & PIN_MASK;
      if (wr_en && bus_addr == OFF_FUNC) func_q  <= bus_wdata & FUNC_MASK;
    end
  end

  always_comb begin
    tmr_vec          = '0;
    tmr_vec[PIN_TA1] = tmr_a1_out;
    tmr_vec[PIN_TA3] = tmr_a3_out;
    tmr_vec[PIN_TB0] = tmr_b0_out0;
  end

  assign timer_sel = dir_q & func_q & TMR_MASK;
  assign irq_mode  = ~dir_q & func_q;
  assign pad_oe    = dir_q;
  assign pad_out   = (timer_sel & tmr_vec) | (~timer_sel & latch_q);

  assign irq_req = {sync2_q[PIN_TB0]  & irq_mode[PIN_TB0],
                    sync2_q[PIN_TA3]  & irq_mode[PIN_TA3],
                    sync2_q[PIN_TA1]  & irq_mode[PIN_TA1],
                    sync2_q[PIN_INT0] & irq_mode[PIN_INT0]};

  assign view      = (dir_q & ~PADRB_MASK & latch_q) | ((~dir_q | PADRB_MASK) & sync2_q);
  assign bus_rdata = (rd_en && bus_addr == OFF_DATA) ? view : '0;
  assign tmr_in0   = sync2_q[PIN_TIN];
endmodule

// File: rtl/gpio_altfn_port_chk.sv
module gpio_altfn_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] pad_in,
  input logic [7:0] pad_out,
  input logic [7:0] pad_oe,
  input logic       tmr_a1_out,
  input logic       tmr_a3_out,
  input logic       tmr_b0_out0,
  input logic       tmr_in0,
  input logic [3:0] irq_req,
  input logic [7:0] dir_q,
  input logic [7:0] func_q
);
  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 8'h32) |=> pad_oe == ($past(bus_wdata) & 8'h6B));

  p_no_unimpl_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & 8'h94) == 8'h00);

  p_timer_pin5_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q[5] && func_q[5]) |-> pad_out[5] == tmr_a3_out);

  p_timer_pin6_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q[6] && func_q[6]) |-> pad_out[6] == tmr_b0_out0);

  p_irq_input_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[1] |-> !pad_oe[1]);

  p_irq_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[2] |-> $past(pad_in[5], 2));

  p_cfg_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == 8'h32 || bus_addr == 8'h33)) |-> bus_rdata == 8'h00);

  p_tmr_in_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_in0 |-> $past(pad_in[0], 2));
endmodule

bind gpio_altfn_port gpio_altfn_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
  .pad_oe(pad_oe), .tmr_a1_out(tmr_a1_out), .tmr_a3_out(tmr_a3_out),
  .tmr_b0_out0(tmr_b0_out0), .tmr_in0(tmr_in0), .irq_req(irq_req),
  .dir_q(dir_q), .func_q(func_q)
);

// File: tb/tb_gpio_altfn_port.sv
`timescale 1ns/1ps
module tb_gpio_altfn_port;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, pad_in = 0;
  logic       tmr_a1_out = 0, tmr_a3_out = 0, tmr_b0_out0 = 0;
  logic [7:0] bus_rdata, pad_out, pad_oe;
  logic       tmr_in0;
  logic [3:0] irq_req;

  int checks = 0, fails = 0;
  logic [7:0] m_latch, m_dir, m_func, m_s1, m_s2;

  always #2 clk = ~clk;

  gpio_altfn_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .tmr_a1_out(tmr_a1_out), .tmr_a3_out(tmr_a3_out),
    .tmr_b0_out0(tmr_b0_out0), .tmr_in0(tmr_in0), .irq_req(irq_req)
  );

  function automatic logic [7:0] exp_out();
    logic [7:0] r = m_latch;
    if (m_dir[1] && m_func[1]) r[1] = tmr_a1_out;
    if (m_dir[5] && m_func[5]) r[5] = tmr_a3_out;
    if (m_dir[6] && m_func[6]) r[6] = tmr_b0_out0;
    return r;
  endfunction

  function automatic logic [3:0] exp_irq();
    return {m_s2[6] & ~m_dir[6] & m_func[6], m_s2[5] & ~m_dir[5] & m_func[5],
            m_s2[1] & ~m_dir[1] & m_func[1], m_s2[3] & ~m_dir[3] & m_func[3]};
  endfunction

  function automatic logic [7:0] exp_rd();
    logic [7:0] v = m_s2 & 8'h6B;
    if (m_dir[3]) v[3] = m_latch[3];
    if (bus_sel && !bus_wr && bus_addr == 8'h30) return v;
    return 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_latch = 8'h6B; m_dir = 0; m_func = 0; m_s1 = 0; m_s2 = 0;
  endtask

  task automatic check_all();
    check("R2 pad_oe", pad_oe, m_dir);
    check("R3 R4 pad_out", pad_out, exp_out());
    check("R5 irq_req", {4'h0, irq_req}, {4'h0, exp_irq()});
    check("R9 tmr_in0", {7'h0, tmr_in0}, {7'h0, m_s2[0]});
    check("R7 R8 bus_rdata", bus_rdata, exp_rd());
  endtask

  task automatic step();
    @(posedge clk);
    m_s2 = m_s1;
    m_s1 = pad_in & 8'h6B;
    if (bus_sel && bus_wr) begin
      if (bus_addr == 8'h30) m_latch = bus_wdata & 8'h6B;
      if (bus_addr == 8'h32) m_dir   = bus_wdata & 8'h6B;
      if (bus_addr == 8'h33) m_func  = bus_wdata & 8'h6A;
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset pad_oe", pad_oe, 8'h00);
    check("R1 reset irq", {4'h0, irq_req}, 8'h00);
    bus_sel = 1; bus_addr = 8'h30;
    #0 check("R1 reset read", bus_rdata, 8'h00);
    bus_sel = 0;

    wr(8'h32, 8'h08);
    check("R1 latch ones on pin3", pad_out & 8'h08, 8'h08);
    rd(8'h30);
    check("R7 pin3 output reads latch", bus_rdata & 8'h08, 8'h08);

    wr(8'h30, 8'hFF);
    wr(8'h32, 8'hFF);
    check("R2 unimplemented never enabled", pad_oe, 8'h6B);
    wr(8'h33, 8'hFF);
    tmr_a1_out = 0; tmr_a3_out = 1; tmr_b0_out0 = 0;
    #0 check("R4 timer routing", pad_out, 8'h29);
    rd(8'h32);
    check("R8 dir reads zero", bus_rdata, 8'h00);
    rd(8'h33);
    check("R8 func reads zero", bus_rdata, 8'h00);
    wr(8'h31, 8'h00);
    check("R10 other offset ignored", pad_out & 8'h09, 8'h09);

    wr(8'h32, 8'h00);
    pad_in = 8'hFF;
    step();
    check("R6 one edge not visible", {4'h0, irq_req}, 8'h00);
    step();
    check("R6 two edges visible", {4'h0, irq_req}, 8'h0F);
    check("R9 tmr_in0 follows pin0", {7'h0, tmr_in0}, 8'h01);
    rd(8'h30);
    check("R8 unimplemented read zero", bus_rdata, 8'h6B);
    wr(8'h33, 8'h01);
    check("R10 pin0 func ignored", {4'h0, irq_req}, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 9);
      bus_sel = ($urandom_range(0, 3) != 0);
      bus_wr = $urandom_range(0, 1);
      bus_addr = (k < 9) ? 8'h30 + 8'(k % 4) : 8'($urandom);
      bus_wdata = 8'($urandom);
      if ($urandom_range(0, 2) == 0) pad_in = 8'($urandom);
      tmr_a1_out = $urandom_range(0, 1);
      tmr_a3_out = $urandom_range(0, 1);
      tmr_b0_out0 = $urandom_range(0, 1);
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule